// File: doc/BRIEF.md
# Boot Page Validity Checker

After reset this block walks the first page of program memory once, one word per cycle, over a plain synchronous read port. While the words stream past it keeps a running 32-bit sum. One reserved word, the check word, is left out of that sum and is held aside.

When the page has been read, the block compares the check word with two references: a fixed signature constant and the sum it has just built. A match on either one lets user code start. If neither matches, the block asks the system to fall back to a serial download mode.

The verdict is announced with a one-cycle done strobe. Both verdict flags then hold their values until the next reset. The page is read in a single pass, because the check word is captured as it goes by.

Top module: `boot_vector_check`

## Requirements
- R1: While rst_ni is low, mem_req_o, done_o, run_user_o and enter_dl_o are all 0.
- R2: The first clock edge after reset release starts the read. mem_req_o is then high for exactly WORDS (= PAGE_BYTES/4, 128 by default) consecutive cycles, with mem_addr_o counting up through word addresses 0..WORDS-1. It is never raised again before the next reset.
- R3: Memory returns the data for an address on mem_rdata_i one cycle after the request that carried it.
- R4: The checksum is the 32-bit wrapping sum of every page word except the check word. The check word is the word at byte address 0x14, which is word index 5.
- R5: A check word equal to 0x27011970 yields run_user_o=1 and enter_dl_o=0.
- R6: A check word equal to the checksum of R4 yields run_user_o=1 and enter_dl_o=0. This includes an all-zero page.
- R7: If the check word matches neither reference, the result is enter_dl_o=1 and run_user_o=0. The signature placed at any other word index does not count.
- R8: done_o is high for exactly one cycle, three cycles after the last read request, which is the edge WORDS+3 counted from reset release. The flags become valid in that same cycle.
- R9: Both flags are 0 before done_o. From done_o on, exactly one flag is 1, and both hold steady until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mem_req_o | output | 1 | Read request to program memory |
| mem_addr_o | output | 7 | Word address of the read |
| mem_rdata_i | input | 32 | Read data, valid one cycle after the request |
| run_user_o | output | 1 | Verdict: start user code |
| enter_dl_o | output | 1 | Verdict: enter download mode |
| done_o | output | 1 | One-cycle strobe when the verdict is ready |

## Verification
The bench fills the page with random words, so the sum wraps past 32 bits. A design that saturates the sum, or truncates it to fewer bits, would reject a valid checksum.

Several cases target the check word:
- A checksum that is off by one must be refused.
- A signature with a single bit flipped must be refused.
- A signature placed in the neighbouring word must be refused. A design that skipped or captured the wrong index, or added the check word into the sum, would give the opposite verdict.
- An all-zero page must be accepted through the checksum path.

The per-cycle model also catches designs that drop the last word because of the read latency, strobe done for more than one cycle, or let the flags move after the verdict.

// File: rtl/boot_chk_pkg.sv
package boot_chk_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_READ    = 2'd1,
    ST_COMPARE = 2'd2,
    ST_DONE    = 2'd3
  } chk_state_e;

  localparam logic [31:0] SIGNATURE = 32'h2701_1970;
endpackage

// File: rtl/boot_chk_addr_gen.sv
module boot_chk_addr_gen #(
  parameter int WORDS = 128,
  localparam int AW = $clog2(WORDS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  output logic          req_o,
  output logic [AW-1:0] addr_o,
  output logic          rvld_o,
  output logic [AW-1:0] ridx_o,
  output logic          last_o
);
  logic [AW:0]   cnt_q;
  logic          rvld_q;
  logic [AW-1:0] ridx_q;

  assign req_o  = en_i && (cnt_q < (AW+1)'(WORDS));
  assign addr_o = cnt_q[AW-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      rvld_q <= 1'b0;
      ridx_q <= '0;
    end else begin
      if (req_o) cnt_q <= cnt_q + 1'b1;
      rvld_q <= req_o;
      if (req_o) ridx_q <= addr_o;
    end
  end

  // data of the final word arrives one cycle after its request
  assign rvld_o = rvld_q;
  assign ridx_o = ridx_q;
  assign last_o = rvld_q && (ridx_q == AW'(WORDS-1));

  a_r2_addr_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && $past(req_o)) |-> (addr_o == $past(addr_o) + 1'b1));

  a_r3_data_follows_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(req_o) |-> (rvld_o && ridx_o == $past(addr_o)));
endmodule

// File: rtl/boot_chk_accum.sv
module boot_chk_accum #(
  parameter int DATA_W    = 32,
  parameter int WORDS     = 128,
  parameter int CHECK_IDX = 5,
  localparam int AW = $clog2(WORDS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              vld_i,
  input  logic [AW-1:0]     idx_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] sum_o,
  output logic [DATA_W-1:0] chk_o
);
  logic [DATA_W-1:0] sum_q, chk_q;
  logic              is_chk;

  assign is_chk = (idx_i == AW'(CHECK_IDX));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sum_q <= '0;
      chk_q <= '0;
    end else if (vld_i) begin
      if (is_chk) chk_q <= data_i;
      else        sum_q <= sum_q + data_i;
    end
  end

  assign sum_o = sum_q;
  assign chk_o = chk_q;

  a_r4_skip_check_word: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_i && idx_i == AW'(CHECK_IDX)) |=> $stable(sum_o));

  a_r4_capture_check_word: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_i && idx_i == AW'(CHECK_IDX)) |=> (chk_o == $past(data_i)));
endmodule

// File: rtl/boot_vector_check.sv
module boot_vector_check #(
  parameter int          PAGE_BYTES      = 512,
  parameter int          DATA_W          = 32,
  parameter int          CHECK_BYTE_ADDR = 20,
  parameter logic [31:0] MAGIC           = boot_chk_pkg::SIGNATURE,
  localparam int WORDS     = PAGE_BYTES / (DATA_W / 8),
  localparam int AW        = $clog2(WORDS),
  localparam int CHECK_IDX = CHECK_BYTE_ADDR / (DATA_W / 8)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic              mem_req_o,
  output logic [AW-1:0]     mem_addr_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              run_user_o,
  output logic              enter_dl_o,
  output logic              done_o
);
  import boot_chk_pkg::*;

  chk_state_e        state_q, state_d;
  logic              rvld, last;
  logic [AW-1:0]     ridx;
  logic [DATA_W-1:0] sum, chk;
  logic              pass;
  logic              run_q, dl_q, done_q;

  boot_chk_addr_gen #(.WORDS(WORDS)) u_addr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (state_q == ST_READ),
    .req_o  (mem_req_o),
    .addr_o (mem_addr_o),
    .rvld_o (rvld),
    .ridx_o (ridx),
    .last_o (last)
  );

  boot_chk_accum #(.DATA_W(DATA_W), .WORDS(WORDS), .CHECK_IDX(CHECK_IDX)) u_acc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .vld_i  (rvld),
    .idx_i  (ridx),
    .data_i (mem_rdata_i),
    .sum_o  (sum),
    .chk_o  (chk)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:    state_d = ST_READ;
      ST_READ:    if (last) state_d = ST_COMPARE;
      ST_COMPARE: state_d = ST_DONE;
      ST_DONE:    state_d = ST_DONE;
      default:    state_d = ST_IDLE;
    endcase
  end

  assign pass = (chk == DATA_W'(MAGIC)) || (chk == sum);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      run_q   <= 1'b0;
      dl_q    <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= (state_q == ST_COMPARE);
      if (state_q == ST_COMPARE) begin
        run_q <= pass;
        dl_q  <= !pass;
      end
    end
  end

  assign run_user_o = run_q;
  assign enter_dl_o = dl_q;
  assign done_o     = done_q;

  a_r8_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r9_one_hot_verdict: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (run_user_o ^ enter_dl_o));

  a_r9_flags_low_before: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_DONE) |-> (!run_user_o && !enter_dl_o));

  a_r9_flags_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DONE && $past(state_q == ST_DONE)) |-> ($stable(run_user_o) && $stable(enter_dl_o)));

  a_r2_no_req_after_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_READ) |-> !mem_req_o);
endmodule

// File: tb/tb_boot_vector_check.sv
module tb_boot_vector_check;
  localparam int WORDS = 128;
  localparam int CIDX  = 5;
  localparam logic [31:0] SIG = 32'h2701_1970;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        mem_req_o;
  logic [6:0]  mem_addr_o;
  logic [31:0] mem_rdata_i = '0;
  logic        run_user_o, enter_dl_o, done_o;

  logic [31:0] mem [WORDS];
  int checks = 0;
  int failures = 0;
  int cycles = 0;

  always #2 clk_i = ~clk_i;

  boot_vector_check dut (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o), .mem_rdata_i(mem_rdata_i),
    .run_user_o(run_user_o), .enter_dl_o(enter_dl_o), .done_o(done_o)
  );

  // R3: memory answers one cycle after the request
  always @(posedge clk_i) if (mem_req_o) mem_rdata_i <= mem[mem_addr_o];

  always @(posedge clk_i) begin
    cycles <= cycles + 1;
    if (cycles > 20000) begin
      failures = failures + 1;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] page_sum();
    logic [31:0] s = '0;
    for (int i = 0; i < WORDS; i++) if (i != CIDX) s += mem[i];
    return s;
  endfunction

  task automatic fill_random();
    for (int i = 0; i < WORDS; i++) mem[i] = $urandom;
  endtask

  task automatic run_case(string name, logic exp_run);
    logic er, ed;
    rst_ni = 1'b0;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    chk({"R1 ", name, " req"},  32'(mem_req_o), 0);
    chk({"R1 ", name, " done"}, 32'(done_o), 0);
    chk({"R1 ", name, " run"},  32'(run_user_o), 0);
    chk({"R1 ", name, " dl"},   32'(enter_dl_o), 0);
    rst_ni = 1'b1;
    for (int n = 1; n <= WORDS + 12; n++) begin
      @(negedge clk_i);
      chk({"R2 ", name, " req"}, 32'(mem_req_o), 32'(n <= WORDS));
      if (n <= WORDS) chk({"R2 ", name, " addr"}, 32'(mem_addr_o), 32'(n - 1));
      chk({"R8 ", name, " done"}, 32'(done_o), 32'(n == WORDS + 3));
      er = (n >= WORDS + 3) ? exp_run : 1'b0;
      ed = (n >= WORDS + 3) ? !exp_run : 1'b0;
      chk({"R9 R5 R6 R7 ", name, " run"}, 32'(run_user_o), 32'(er));
      chk({"R9 R7 ", name, " dl"},        32'(enter_dl_o), 32'(ed));
    end
  endtask

  initial begin
    // R5: signature in the check word
    fill_random(); mem[CIDX] = SIG;
    run_case("sig", 1'b1);
    // R4 R6: wrapped checksum in the check word
    fill_random(); mem[CIDX] = page_sum();
    run_case("sum", 1'b1);
    // R7: neither reference matches
    fill_random(); mem[CIDX] = page_sum() ^ 32'h00F0_0000;
    run_case("bad", 1'b0);
    // R6: all-zero page passes through the checksum path
    for (int i = 0; i < WORDS; i++) mem[i] = '0;
    run_case("zero", 1'b1);
    // R7: one signature bit flipped
    fill_random(); mem[CIDX] = SIG ^ 32'h0000_0001;
    run_case("sigflip", 1'b0);
    // R7: signature in the wrong word
    fill_random(); mem[CIDX - 1] = SIG; mem[CIDX] = 32'hDEAD_BEEF;
    if (page_sum() == 32'hDEAD_BEEF) mem[0] = mem[0] + 1;
    run_case("sigmoved", 1'b0);
    // R4: checksum off by one
    fill_random(); mem[CIDX] = page_sum() + 1;
    run_case("sumoff", 1'b0);
    // R4: checksum that wrongly includes the check word itself
    fill_random(); mem[CIDX] = 32'h0000_1000;
    mem[CIDX] = page_sum() + mem[CIDX];
    run_case("sumself", 1'b0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule